// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block connects two 18-bit data ports, side A and side B, through two separate storage paths: one carries A toward B and the other carries B toward A. Each path has four control inputs of its own: a drive enable, a pass-through enable, a capture gate and a path strobe. When the pass-through enable is high, the path's storage follows its input. When it is low, the storage holds its value. It loads new data only on a rising path strobe, and only while the capture gate is low.

All inputs are sampled by a fast system clock. Each path's data and controls go through the same synchronizer chain, `SYNC_STAGES` flops deep, so they stay aligned. The rising edge of the path strobe is found by comparing the synchronized strobe with its value one system cycle earlier. Each output port is a data bus plus a drive flag, which stands in for a tri-state driver. While the flag is low, the bus reads zero.

A change on any input shows at the opposite port `SYNC_STAGES + 1` system clock cycles later.

Top module: `bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both drive flags are 0 and both output buses read 0. After reset, both storage elements hold 0.
- R2: When a path's pass-through enable is 1, the output of that path shows the path input sampled `SYNC_STAGES + 1` cycles earlier, every cycle.
- R3: When pass-through enable is 0 and the synchronized strobe shows no rising edge, the stored value does not change, whatever the input data does.
- R4: When pass-through enable is 0 and the capture gate is 0, a rising edge of the path strobe loads the aligned input data into storage.
- R5: A rising strobe edge while the capture gate is 1 leaves the stored value unchanged.
- R6: The drive flag of a path equals its drive enable delayed by `SYNC_STAGES + 1` cycles. While the flag is 0, the output bus is all zeros.
- R7: When pass-through enable falls, the storage keeps the last value that passed through.
- R8: The two paths are independent. With both drive enables high, `b_out` carries A-side data and `a_out` carries B-side data at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | A-side data entering the A-to-B path |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B pass-through enable, active high |
| ab_ce | input | 1 | A-to-B capture gate, active low |
| ab_clk | input | 1 | A-to-B path strobe, rising edge captures |
| b_in | input | 18 | B-side data entering the B-to-A path |
| ba_oe | input | 1 | B-to-A drive enable, active high |
| ba_le | input | 1 | B-to-A pass-through enable, active high |
| ba_ce | input | 1 | B-to-A capture gate, active low |
| ba_clk | input | 1 | B-to-A path strobe, rising edge captures |
| b_out | output | 18 | B-side output bus, zero when not driven |
| b_drive | output | 1 | B-side drive flag |
| a_out | output | 18 | A-side output bus, zero when not driven |
| a_drive | output | 1 | A-side drive flag |

## Verification
The assertions read the synchronized view of each path. They assume that every input is sampled cleanly by the system clock, so a path strobe counts as rising only when it holds each level for at least one system cycle. The bench drives every input at the falling edge of the system clock and changes the strobes at most once per cycle, so each strobe transition arrives as exactly one clean level change at the synchronizer. The random phase mixes all control combinations, including strobe edges that arrive with the capture gate high and edges that arrive during pass-through, so the hold and gating paths are both exercised.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Per-path control bundle, all active high except capture_n
    typedef struct packed {
        logic drive_en;   // output drive enable
        logic pass_en;    // transparent pass-through
        logic capture_n;  // capture gate, low allows strobe capture
        logic strobe;     // path strobe, rising edge captures
    } path_ctl_t;

    localparam int CTL_W   = $bits(path_ctl_t);
    localparam int NUM_DIR = 2;   // 0: A to B, 1: B to A

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int W      = 22,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  path_ctl_t        ctl,
    output logic [WIDTH-1:0] store,
    output logic             drive,
    output logic             rise
);
    typedef struct packed {
        logic [WIDTH-1:0] store;
        logic             drive;
        logic             strobe_prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        rise             = ctl.strobe & ~st_q.strobe_prev;
        st_d.strobe_prev = ctl.strobe;
        st_d.drive       = ctl.drive_en;
        if (ctl.pass_en) begin
            st_d.store = din;
        end else if (rise && !ctl.capture_n) begin
            st_d.store = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign store = st_q.store;
    assign drive = st_q.drive;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_ce,
    input  logic             ab_clk,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ba_oe,
    input  logic             ba_le,
    input  logic             ba_ce,
    input  logic             ba_clk,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive
);
    localparam int SYNC_W = WIDTH + CTL_W;

    logic [WIDTH-1:0] din_raw [NUM_DIR];
    path_ctl_t        ctl_raw [NUM_DIR];
    logic [WIDTH-1:0] din_s   [NUM_DIR];
    path_ctl_t        ctl_s   [NUM_DIR];
    logic [WIDTH-1:0] store_q [NUM_DIR];
    logic             drive_q [NUM_DIR];
    logic             rise_s  [NUM_DIR];

    assign din_raw[0] = a_in;
    assign ctl_raw[0] = '{drive_en: ab_oe, pass_en: ab_le, capture_n: ab_ce, strobe: ab_clk};
    assign din_raw[1] = b_in;
    assign ctl_raw[1] = '{drive_en: ba_oe, pass_en: ba_le, capture_n: ba_ce, strobe: ba_clk};

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        logic [SYNC_W-1:0] sync_q;

        xcvr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     ({ctl_raw[g], din_raw[g]}),
            .q     (sync_q)
        );

        assign din_s[g] = sync_q[WIDTH-1:0];
        assign ctl_s[g] = path_ctl_t'(sync_q[SYNC_W-1:WIDTH]);

        xcvr_path #(.WIDTH(WIDTH)) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (din_s[g]),
            .ctl   (ctl_s[g]),
            .store (store_q[g]),
            .drive (drive_q[g]),
            .rise  (rise_s[g])
        );
    end

    assign b_out   = drive_q[0] ? store_q[0] : '0;
    assign b_drive = drive_q[0];
    assign a_out   = drive_q[1] ? store_q[1] : '0;
    assign a_drive = drive_q[1];
endmodule

// File: rtl/xcvr_checks.sv
module xcvr_checks
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input path_ctl_t        ab_ctl,
    input logic [WIDTH-1:0] ab_din,
    input logic             ab_rise,
    input logic [WIDTH-1:0] ab_store,
    input logic             ab_flag,
    input path_ctl_t        ba_ctl,
    input logic [WIDTH-1:0] ba_din,
    input logic             ba_rise,
    input logic [WIDTH-1:0] ba_store,
    input logic             ba_flag
);
    p_follow_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ab_ctl.pass_en |=> ab_store == $past(ab_din));
    p_follow_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ba_ctl.pass_en |=> ba_store == $past(ba_din));

    p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ctl.pass_en && !ab_rise) |=> $stable(ab_store));
    p_hold_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_ctl.pass_en && !ba_rise) |=> $stable(ba_store));

    p_capture_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ctl.pass_en && !ab_ctl.capture_n && ab_rise) |=> ab_store == $past(ab_din));
    p_capture_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_ctl.pass_en && !ba_ctl.capture_n && ba_rise) |=> ba_store == $past(ba_din));

    p_gate_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ctl.pass_en && ab_ctl.capture_n) |=> $stable(ab_store));
    p_gate_ba_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_ctl.pass_en && ba_ctl.capture_n) |=> $stable(ba_store));

    p_drive_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ab_ctl.drive_en |=> ab_flag);
    p_quiet_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_ctl.drive_en |=> !ab_flag);
    p_drive_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ba_ctl.drive_en |=> ba_flag);
    p_quiet_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_ctl.drive_en |=> !ba_flag);
endmodule

bind bus_xcvr xcvr_checks #(.WIDTH(WIDTH)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .ab_ctl   (ctl_s[0]),
    .ab_din   (din_s[0]),
    .ab_rise  (rise_s[0]),
    .ab_store (store_q[0]),
    .ab_flag  (b_drive),
    .ba_ctl   (ctl_s[1]),
    .ba_din   (din_s[1]),
    .ba_rise  (rise_s[1]),
    .ba_store (store_q[1]),
    .ba_flag  (a_drive)
);

// File: tb/bus_xcvr_test.sv
`timescale 1ns/1ps
module bus_xcvr_test;
    localparam int W   = 18;
    localparam int N   = 2;
    localparam int LAT = N + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_oe = 0, ab_le = 0, ab_ce = 1, ab_clk = 0;
    logic ba_oe = 0, ba_le = 0, ba_ce = 1, ba_clk = 0;
    logic [W-1:0] b_out, a_out;
    logic b_drive, a_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bus_xcvr #(.WIDTH(W), .SYNC_STAGES(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .ab_oe(ab_oe), .ab_le(ab_le), .ab_ce(ab_ce), .ab_clk(ab_clk),
        .b_in(b_in), .ba_oe(ba_oe), .ba_le(ba_le), .ba_ce(ba_ce), .ba_clk(ba_clk),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    // ---------------- reference model ----------------
    typedef struct {
        logic [W-1:0] d;
        bit oe, le, ce, ck;
    } smp_t;

    smp_t         hist0[$], hist1[$];
    logic [W-1:0] m_store [2];
    bit           m_drv   [2];
    string        m_tag   [2];

    function automatic void model_clear();
        smp_t z;
        z = '{d: '0, oe: 0, le: 0, ce: 0, ck: 0};
        hist0.delete(); hist1.delete();
        for (int i = 0; i < N + 1; i++) begin
            hist0.push_back(z); hist1.push_back(z);
        end
        for (int k = 0; k < 2; k++) begin
            m_store[k] = '0; m_drv[k] = 0; m_tag[k] = "R1";
        end
    endfunction

    function automatic void model_step(int k, smp_t x, smp_t xp);
        bit up;
        up = x.ck && !xp.ck;
        if (x.le) begin
            m_store[k] = x.d; m_tag[k] = "R2";
        end else if (up && !x.ce) begin
            m_store[k] = x.d; m_tag[k] = "R4";
        end else if (up) begin
            m_tag[k] = "R5";
        end else begin
            m_tag[k] = "R3";
        end
        m_drv[k] = x.oe;
    endfunction

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            hist0.push_back('{d: a_in, oe: ab_oe, le: ab_le, ce: ab_ce, ck: ab_clk});
            hist1.push_back('{d: b_in, oe: ba_oe, le: ba_le, ce: ba_ce, ck: ba_clk});
            model_step(0, hist0[hist0.size()-1-N], hist0[hist0.size()-2-N]);
            model_step(1, hist1[hist1.size()-1-N], hist1[hist1.size()-2-N]);
            if (hist0.size() > N + 2) void'(hist0.pop_front());
            if (hist1.size() > N + 2) void'(hist1.pop_front());
        end
    end

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6", "b_drive", W'(b_drive), W'(m_drv[0]));
            check("R6", "a_drive", W'(a_drive), W'(m_drv[1]));
            check(m_tag[0], "b_out model", b_out, m_drv[0] ? m_store[0] : '0);
            check(m_tag[1], "a_out model", a_out, m_drv[1] ? m_store[1] : '0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        tick(LAT + 2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        tick(4);
        // R1: reset state
        check("R1", "b_drive in reset", W'(b_drive), '0);
        check("R1", "a_drive in reset", W'(a_drive), '0);
        check("R1", "b_out in reset", b_out, '0);
        check("R1", "a_out in reset", a_out, '0);
        rst_n = 1'b1;
        ab_oe = 1; settle();
        check("R1", "store after reset", b_out, '0);

        // R2: pass-through follows input
        ab_le = 1; a_in = 18'h2A5A5; settle();
        check("R2", "pass value 1", b_out, 18'h2A5A5);
        a_in = 18'h15A5A; tick(LAT);
        check("R2", "pass latency", b_out, 18'h15A5A);

        // R7: falling pass enable keeps last value
        ab_le = 0; tick(1); a_in = 18'h3FFFF; settle();
        check("R7", "hold after pass", b_out, 18'h15A5A);

        // R4: capture on rising strobe
        ab_ce = 0; a_in = 18'h01234; tick(1); ab_clk = 1; settle();
        check("R4", "capture", b_out, 18'h01234);

        // R3: strobe held high, data changes
        a_in = 18'h0ABCD; settle();
        check("R3", "hold strobe high", b_out, 18'h01234);
        ab_clk = 0; settle();
        check("R3", "falling strobe ignored", b_out, 18'h01234);

        // R5: capture gate high blocks edge
        ab_ce = 1; tick(1); ab_clk = 1; settle();
        check("R5", "gated edge", b_out, 18'h01234);
        ab_clk = 0;

        // R6: drive disabled gives zero bus
        ab_oe = 0; settle();
        check("R6", "b_drive off", W'(b_drive), '0);
        check("R6", "b_out zero", b_out, '0);

        // R8: both directions driven independently
        ab_oe = 1; ba_oe = 1; ba_le = 1; b_in = 18'h0BEEF; settle();
        check("R8", "a_out from B side", a_out, 18'h0BEEF);
        check("R8", "b_out from A side", b_out, 18'h01234);
        ba_le = 0; tick(1); b_in = 18'h11111; ab_le = 1; a_in = 18'h22222; settle();
        check("R8", "a_out held", a_out, 18'h0BEEF);
        check("R8", "b_out passes", b_out, 18'h22222);

        // random phase, compared by the model every cycle
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            a_in  = W'($urandom);
            b_in  = W'($urandom);
            ab_le = (r < 15);
            ba_le = ($urandom_range(0, 99) < 15);
            if ($urandom_range(0, 3) == 0) ab_ce = ~ab_ce;
            if ($urandom_range(0, 3) == 0) ba_ce = ~ba_ce;
            if ($urandom_range(0, 2) == 0) ab_clk = ~ab_clk;
            if ($urandom_range(0, 2) == 0) ba_clk = ~ba_clk;
            if ($urandom_range(0, 15) == 0) ab_oe = ~ab_oe;
            if ($urandom_range(0, 15) == 0) ba_oe = ~ba_oe;
            tick(1);
        end
        settle();

        // R1: reset again mid-run
        rst_n = 0; tick(2);
        check("R1", "b_out re-reset", b_out, '0);
        check("R1", "a_drive re-reset", W'(a_drive), '0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule